// File: doc/BRIEF.md
# Four-Opcode Byte Processor

A very small 8-bit processor core. It reads its program one byte at a time from a synchronous program memory: it presents an address on `prog_addr` and takes the byte back on `prog_data` one clock later. It understands four byte opcodes. Two of them load the byte that follows into a working register. One adds two working registers. One pushes the accumulator out through a result port that has a one-cycle valid strobe. It holds four 8-bit general registers: AX, BX, CX and DX. A controller steps every instruction through four phases in the same order: fetch, decode, execute, store.

Every instruction takes exactly four clock cycles, including those that carry an immediate byte. The program counter advances once in decode. It advances once more in execute when the opcode takes an operand. Any byte that is not one of the four opcodes does nothing and moves the program counter on by one byte. The sum wraps modulo 256, and no carry or flag state is kept.

Top module: `tiny_byte_core`

## Requirements
- R1: After a synchronous active-high reset, `prog_addr` is 0 and `out_valid` is 0. `out_data` is 0, and AX and BX hold 0, so an output opcode run first emits 0.
- R2: Opcode 0x80 writes the program byte that follows it into AX.
- R3: Opcode 0x90 writes the program byte that follows it into BX. BX keeps that value through later additions.
- R4: Opcode 0xB0 writes (AX + BX) mod 256 into AX and leaves BX unchanged.
- R5: Opcode 0xC0 drives AX on `out_data` with `out_valid` high for exactly one cycle. Otherwise `out_data` holds its last value.
- R6: A byte other than 0x80, 0x90, 0xB0 or 0xC0 changes no register and no output, and advances the program counter by one byte.
- R7: Every instruction takes four cycles. The address advances by one after the opcode is read, and by one more for 0x80 and 0x90. For a program that starts at address 0 after reset, the strobe of its fourth instruction appears 16 cycles after reset is released.
- R8: The program 80 01 90 02 B0 C0 (hex) emits the single value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_addr | output | ADDR_W | Program memory read address (the program counter) |
| prog_data | input | DATA_W | Byte read back from the program memory, one cycle after the address |
| out_data | output | DATA_W | Last value pushed out by the output opcode |
| out_valid | output | 1 | One-cycle strobe marking a new `out_data` |

## Verification
The hardest thing to see from the ports is the state inside the registers and the program counter. The only window onto them is the output opcode. The stimulus therefore places 0xC0 bytes just after the instructions under test. It places unknown bytes between them, so a wrong one-byte skip after a no-op would misalign the stream and show up in the emitted values. A cycle-by-cycle model predicts the address, the strobe and the data on every clock. The latency of the first strobe and the four-cycle spacing of back-to-back output opcodes are measured directly. The overflow case is driven by operands whose sum is greater than 255.

// File: rtl/bytecore_pkg.sv
package bytecore_pkg;

   localparam logic [7:0] OPC_LOAD_A = 8'h80;
   localparam logic [7:0] OPC_LOAD_B = 8'h90;
   localparam logic [7:0] OPC_SUM    = 8'hB0;
   localparam logic [7:0] OPC_EMIT   = 8'hC0;

   localparam int REG_AX = 0;
   localparam int REG_BX = 1;

   typedef enum logic [1:0] {
      PH_FETCH  = 2'd0,
      PH_DECODE = 2'd1,
      PH_EXEC   = 2'd2,
      PH_STORE  = 2'd3
   } phase_e;

   typedef enum logic [2:0] {
      K_NOP = 3'd0,
      K_LDA = 3'd1,
      K_LDB = 3'd2,
      K_ADD = 3'd3,
      K_OUT = 3'd4
   } opkind_e;

   typedef struct packed {
      logic       takes_imm;
      logic       wr_en;
      logic       wr_from_alu;
      logic [1:0] wr_idx;
      logic       emit;
   } ctl_s;

   function automatic opkind_e classify(input logic [7:0] b);
      opkind_e k;
      case (b)
         OPC_LOAD_A: k = K_LDA;
         OPC_LOAD_B: k = K_LDB;
         OPC_SUM:    k = K_ADD;
         OPC_EMIT:   k = K_OUT;
         default:    k = K_NOP;
      endcase
      return k;
   endfunction

   function automatic ctl_s controls(input opkind_e k);
      ctl_s c;
      c = '0;
      case (k)
         K_LDA: begin
            c.takes_imm = 1'b1;
            c.wr_en     = 1'b1;
            c.wr_idx    = 2'(REG_AX);
         end
         K_LDB: begin
            c.takes_imm = 1'b1;
            c.wr_en     = 1'b1;
            c.wr_idx    = 2'(REG_BX);
         end
         K_ADD: begin
            c.wr_en       = 1'b1;
            c.wr_from_alu = 1'b1;
            c.wr_idx      = 2'(REG_AX);
         end
         K_OUT:   c.emit = 1'b1;
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/bytecore_seq.sv
module bytecore_seq
   import bytecore_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [7:0]        fetch_byte,
   output phase_e            phase,
   output logic [ADDR_W-1:0] pc,
   output ctl_s              ctl,
   output logic              in_store
);

   localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

   phase_e  phase_q;
   opkind_e op_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_FETCH;
         pc      <= '0;
         op_q    <= K_NOP;
      end else begin
         case (phase_q)
            PH_FETCH: begin
               phase_q <= PH_DECODE;
            end
            PH_DECODE: begin
               op_q    <= classify(fetch_byte);
               pc      <= pc + PC_ONE;
               phase_q <= PH_EXEC;
            end
            PH_EXEC: begin
               if (controls(op_q).takes_imm) begin
                  pc <= pc + PC_ONE;
               end
               phase_q <= PH_STORE;
            end
            default: begin
               phase_q <= PH_FETCH;
            end
         endcase
      end
   end

   always_comb begin
      phase    = phase_q;
      ctl      = controls(op_q);
      in_store = (phase_q == PH_STORE);
   end

endmodule

// File: rtl/bytecore_regs.sv
module bytecore_regs #(
   parameter int DATA_W = 8,
   parameter int NREGS  = 4,
   localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_a_idx,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b
);

   logic [DATA_W-1:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            regs[i] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            regs[i] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_a = '0;
      rd_b = '0;
      for (int i = 0; i < NREGS; i++) begin
         if (rd_a_idx == IDX_W'(i)) rd_a = regs[i];
         if (rd_b_idx == IDX_W'(i)) rd_b = regs[i];
      end
   end

endmodule

// File: rtl/bytecore_adder.sv
module bytecore_adder #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);

   if (RIPPLE) begin : g_ripple
      logic [W:0] carry;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum[i]     = a[i] ^ b[i] ^ carry[i];
         assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
      end
      logic carry_out_unused;
      assign carry_out_unused = carry[W];
   end else begin : g_behav
      assign sum = a + b;
   end

endmodule

// File: rtl/bytecore_port.sv
module bytecore_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              vld
);

   always_ff @(posedge clk) begin
      if (rst) begin
         dout <= '0;
         vld  <= 1'b0;
      end else begin
         vld <= load;
         if (load) begin
            dout <= din;
         end
      end
   end

endmodule

// File: rtl/tiny_byte_core.sv
module tiny_byte_core
   import bytecore_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int NREGS      = 4,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] prog_addr,
   input  logic [DATA_W-1:0] prog_data,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid
);

   localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("tiny_byte_core: DATA_W must be 8, opcodes are bytes");
   end
   if (NREGS < 2) begin : g_bad_regs
      $error("tiny_byte_core: NREGS must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("tiny_byte_core: ADDR_W must be positive");
   end

   phase_e            cur_phase;
   ctl_s              ctl;
   logic              in_store;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] opb;
   logic [DATA_W-1:0] sum;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;
   logic              emit;

   bytecore_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .fetch_byte (prog_data[7:0]),
      .phase      (cur_phase),
      .pc         (prog_addr),
      .ctl        (ctl),
      .in_store   (in_store)
   );

   assign wr_en   = in_store & ctl.wr_en;
   assign wr_data = ctl.wr_from_alu ? sum : prog_data;
   assign emit    = in_store & ctl.emit;

   bytecore_regs #(.DATA_W(DATA_W), .NREGS(NREGS)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_idx   (IDX_W'(ctl.wr_idx)),
      .wr_data  (wr_data),
      .rd_a_idx (IDX_W'(REG_AX)),
      .rd_b_idx (IDX_W'(REG_BX)),
      .rd_a     (acc),
      .rd_b     (opb)
   );

   bytecore_adder #(.W(DATA_W), .RIPPLE(RIPPLE_ADD)) u_add (
      .a   (acc),
      .b   (opb),
      .sum (sum)
   );

   bytecore_port #(.DATA_W(DATA_W)) u_port (
      .clk  (clk),
      .rst  (rst),
      .load (emit),
      .din  (acc),
      .dout (out_data),
      .vld  (out_valid)
   );

endmodule

// File: rtl/bytecore_chk.sv
module bytecore_chk
   import bytecore_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] prog_addr,
   input logic [DATA_W-1:0] out_data,
   input logic              out_valid,
   input phase_e            phase
);

   AST_RESET_STATE: assert property (@(posedge clk)
      $past(rst) |-> (prog_addr == '0 && !out_valid && out_data == '0)); // R1

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid); // R5

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_data)); // R5

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
      (prog_addr == $past(prog_addr)) ||
      (prog_addr == ADDR_W'($past(prog_addr) + 1'b1))); // R7

   AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_FETCH) |=> (phase == PH_DECODE)); // R7

   AST_DECODE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_DECODE) |=> (prog_addr == ADDR_W'($past(prog_addr) + 1'b1))); // R6

endmodule

bind tiny_byte_core bytecore_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .prog_addr (prog_addr),
   .out_data  (out_data),
   .out_valid (out_valid),
   .phase     (cur_phase)
);

// File: tb/tiny_byte_core_test.sv
module tiny_byte_core_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] prog_addr;
   logic [7:0] prog_data;
   logic [7:0] out_data;
   logic       out_valid;

   logic [7:0] mem [256];
   logic [7:0] mem_q;

   int checks   = 0;
   int failures = 0;
   int cyc      = 0;

   // reference model state
   int         m_ph;
   int         m_pc;
   logic [7:0] m_ir, m_opnd, m_ax, m_bx, m_out;
   logic       m_vld;

   logic [7:0] obs [$];
   int         first_lat;
   int         second_lat;

   always #10 clk = ~clk;

   tiny_byte_core uut (
      .clk       (clk),
      .rst       (rst),
      .prog_addr (prog_addr),
      .prog_data (prog_data),
      .out_data  (out_data),
      .out_valid (out_valid)
   );

   always @(posedge clk) mem_q <= mem[prog_addr];
   assign prog_data = mem_q;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst) begin
         m_ph = 0; m_pc = 0; m_ir = 8'h00; m_opnd = 8'h00;
         m_ax = 8'h00; m_bx = 8'h00; m_out = 8'h00; m_vld = 1'b0;
      end else begin
         m_vld = 1'b0;
         case (m_ph)
            0: m_ph = 1;
            1: begin
               m_ir = mem[m_pc];
               m_pc = (m_pc + 1) % 256;
               m_ph = 2;
            end
            2: begin
               if (m_ir == 8'h80 || m_ir == 8'h90) begin
                  m_opnd = mem[m_pc];
                  m_pc   = (m_pc + 1) % 256;
               end
               m_ph = 3;
            end
            default: begin
               if (m_ir == 8'h80) m_ax = m_opnd;
               else if (m_ir == 8'h90) m_bx = m_opnd;
               else if (m_ir == 8'hB0) m_ax = m_ax + m_bx;
               else if (m_ir == 8'hC0) begin
                  m_out = m_ax;
                  m_vld = 1'b1;
               end
               m_ph = 0;
            end
         endcase
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst) begin
         checks++;
         if (prog_addr != 8'(m_pc) || out_valid != m_vld ||
             (m_vld && out_data != m_out)) begin
            failures++;
            $display("FAIL R7/R5 cycle %0d: addr=%0h vld=%0b data=%0h expected addr=%0h vld=%0b data=%0h",
                     cyc, prog_addr, out_valid, out_data, m_pc[7:0], m_vld, m_out);
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_prog(input logic [7:0] prog[$], input int ncyc);
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
      for (int i = 0; i < prog.size(); i++) mem[i] = prog[i];
      @(negedge clk);
      @(negedge clk);
      obs.delete();
      first_lat  = -1;
      second_lat = -1;
      rst = 1'b0;
      for (int i = 1; i <= ncyc; i++) begin
         @(negedge clk);
         if (out_valid) begin
            obs.push_back(out_data);
            if (first_lat < 0) first_lat = i;
            else if (second_lat < 0) second_lat = i;
         end
      end
   endtask

   task automatic expect_outputs(input string tag, input logic [7:0] exp[$]);
      check({tag, " count"}, obs.size(), exp.size());
      for (int i = 0; i < exp.size() && i < obs.size(); i++)
         check({tag, " value"}, obs[i], exp[i]);
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check("R1 addr in reset", prog_addr, 0);
      check("R1 valid in reset", out_valid, 0);
      check("R1 data in reset", out_data, 0);

      // R1: AX cleared by reset, emitted first
      run_prog('{8'hC0}, 12);
      expect_outputs("R1 ax after reset", '{8'h00});

      // R8, R2, R3, R4, R7: reference program and latency
      run_prog('{8'h80, 8'h01, 8'h90, 8'h02, 8'hB0, 8'hC0}, 40);
      expect_outputs("R8 reference program", '{8'h03});
      check("R7 first strobe latency", first_lat, 16);

      // R2: immediate loaded into AX
      run_prog('{8'h80, 8'hA7, 8'hC0}, 24);
      expect_outputs("R2 load AX", '{8'hA7});

      // R4: sum wraps modulo 256
      run_prog('{8'h80, 8'hF0, 8'h90, 8'h20, 8'hB0, 8'hC0}, 40);
      expect_outputs("R4 wrap", '{8'h10});

      // R4: repeated additions accumulate
      run_prog('{8'h80, 8'h01, 8'h90, 8'h01, 8'hB0, 8'hB0, 8'hC0}, 44);
      expect_outputs("R4 accumulate", '{8'h03});

      // R3: BX keeps its value across additions
      run_prog('{8'h90, 8'h05, 8'h80, 8'h00, 8'hB0, 8'hB0, 8'hC0}, 44);
      expect_outputs("R3 load BX", '{8'h0A});

      // R6: unknown bytes change nothing and skip exactly one byte
      run_prog('{8'h80, 8'h55, 8'h07, 8'hC0, 8'h12, 8'hC0, 8'h00, 8'h90, 8'h33, 8'hC0}, 60);
      expect_outputs("R6 no-op", '{8'h55, 8'h55, 8'h55});

      // R5, R7: back-to-back output opcodes, one-cycle strobes 4 cycles apart
      run_prog('{8'h80, 8'h2C, 8'hC0, 8'hC0}, 32);
      expect_outputs("R5 repeat emit", '{8'h2C, 8'h2C});
      check("R7 strobe spacing", second_lat - first_lat, 4);
      check("R5 data held after strobe", out_data, 8'h2C);
      check("R5 valid low after strobe", out_valid, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule